// File: doc/BRIEF.md
# Dual-ADC Line Merger with CRC10 Trailer

This block interleaves the samples of two 10-bit converters into a single word stream and closes every image line with a 10-bit checksum word. Each accepted sample pair comes out over two consecutive cycles, converter A first and then converter B. The output therefore runs at twice the per-converter pair rate.

The checksum of a line starts from the first pixel of that line, which is loaded into the register as the seed and is not itself run through the update. Every later pixel of the line, up to and including the last B sample, is folded in one whole word per clock. The folding uses the generator x^10 + x^9 + x^6 + x^3 + x^2 + x + 1. When the checksum enable is high, the checksum word is placed directly after the last pixel.

Whenever no pixel or checksum word is due, a programmable training word goes out so that the receiver can find word alignment. A force input makes the training word replace whatever word is due.

Top module: `line_crc_merger`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0 and `dout_vld` becomes 0 after that edge.
- R2: If the block is idle and `pair_vld` is high at a clock edge, `dout` shows `adc_a` after that edge and `adc_b` after the next edge, with `dout_vld` high for both words.
- R3: The checksum register loads the A sample of a pair that has `line_start` set, without an update. Each later pixel of the line is folded in MSB first: the feedback bit is crc[9] XOR the data bit, the register shifts left, and the mask 10'h24F is XORed in when the feedback bit is 1.
- R4: If a pair has `line_end` high, belongs to an open line and has `crc_en` high, the checksum word follows the B sample in the next cycle with `dout_vld` high.
- R5: If `crc_en` is low on the ending pair, no checksum slot is added. The cycle after the B sample carries a training word, or the A sample of the next pair.
- R6: When no pixel or checksum word is due, `dout` carries `train_word` and `dout_vld` is low.
- R7: When `train_force` is high at an edge, `dout` shows `train_word` and `dout_vld` is low after that edge. The word that was due is consumed, and the checksum still covers it.
- R8: A pair presented while a B sample or a checksum word is still pending is ignored: it produces no output words.
- R9: A `line_start` that arrives while a line is still open reseeds the checksum from the new A sample and drops the partial checksum.
- R10: A pair that arrives while no line is open and without `line_start` passes through the mux. It leaves the checksum untouched and appends no checksum word, even if `line_end` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_a | input | PIX_W | Sample from converter A |
| adc_b | input | PIX_W | Sample from converter B |
| pair_vld | input | 1 | The A/B pair is presented this cycle |
| line_start | input | 1 | The pair opens a line |
| line_end | input | 1 | The pair closes the line |
| crc_en | input | 1 | Append the checksum when this pair ends a line |
| train_force | input | 1 | Replace the output word with the training word |
| train_word | input | PIX_W | Programmable training pattern |
| dout | output | PIX_W | Output word |
| dout_vld | output | 1 | The output word is a pixel or a checksum |

## Verification
The bench builds the block with its default parameters: 10-bit words and the 10'h24F generator mask. The compact word width makes every feedback path of the checksum register reachable through random pixel data. Directed lines cover single-pair lines, lines that end with and without the checksum, mid-line restarts, forced training words and pairs presented while the block is busy. A long random phase then mixes all markers on every cycle, and each output word is compared with a behavioural queue model.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    // Which word the sequencer owes the output on the coming edge.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_B    = 2'd1,
        SLOT_CRC  = 2'd2
    } slot_e;

    localparam int unsigned DEF_PIX_W = 10;
    localparam logic [9:0]  DEF_POLY  = 10'h24F;

endpackage

// File: rtl/lcm_crc_unit.sv
module lcm_crc_unit #(
    parameter int unsigned W    = 10,
    parameter logic [W-1:0] POLY = 10'h24F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_en,
    input  logic         fold_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);

    // One whole word folded per clock; the loop unrolls into XOR trees.
    function automatic logic [W-1:0] fold_word(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r;
        logic         fb;
        r = c;
        for (int i = W - 1; i >= 0; i--) begin
            fb = r[W-1] ^ d[i];
            r  = {r[W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= '0;
        else if (seed_en) crc_q <= din;
        else if (fold_en) crc_q <= fold_word(crc_q, din);
    end

    // R3: a seed load takes the presented word unchanged
    p_seed_load_r3: assert property (@(posedge clk) disable iff (rst)
        seed_en |=> crc_q == $past(din));

    // R3: with neither load nor fold the checksum holds
    p_crc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!seed_en && !fold_en) |=> $stable(crc_q));

endmodule

// File: rtl/lcm_out_stage.sv
module lcm_out_stage #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         have_data,
    input  logic [W-1:0] data_word,
    input  logic         force_train,
    input  logic [W-1:0] train_word,
    output logic [W-1:0] dout,
    output logic         dout_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else if (have_data && !force_train) begin
            dout     <= data_word;
            dout_vld <= 1'b1;
        end else begin
            dout     <= train_word;
            dout_vld <= 1'b0;
        end
    end

    // R7: a forced edge never yields a valid word
    p_force_invalid_r7: assert property (@(posedge clk) disable iff (rst)
        force_train |=> (!dout_vld && dout == $past(train_word)));

    // R6: an edge with nothing due yields the training word
    p_idle_training_r6: assert property (@(posedge clk) disable iff (rst)
        !have_data |=> (!dout_vld && dout == $past(train_word)));

endmodule

// File: rtl/line_crc_merger.sv
module line_crc_merger
    import lcm_pkg::*;
#(
    parameter int unsigned     PIX_W    = DEF_PIX_W,
    parameter logic [PIX_W-1:0] CRC_POLY = DEF_POLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] adc_a,
    input  logic [PIX_W-1:0] adc_b,
    input  logic             pair_vld,
    input  logic             line_start,
    input  logic             line_end,
    input  logic             crc_en,
    input  logic             train_force,
    input  logic [PIX_W-1:0] train_word,
    output logic [PIX_W-1:0] dout,
    output logic             dout_vld
);

    slot_e            slot;
    logic [PIX_W-1:0] hold_b;
    logic             end_pend;
    logic             crc_pend;
    logic             in_line;

    logic             accept;
    logic             seed_en;
    logic             fold_en;
    logic [PIX_W-1:0] fold_din;
    logic [PIX_W-1:0] crc_q;
    logic             have_data;
    logic [PIX_W-1:0] data_word;

    // Pairs are taken only when nothing is owed (R8).
    assign accept   = (slot == SLOT_IDLE) && pair_vld;
    assign seed_en  = accept && line_start;
    assign fold_en  = (accept && !line_start && in_line) || ((slot == SLOT_B) && in_line);
    assign fold_din = (slot == SLOT_B) ? hold_b : adc_a;

    always_comb begin
        have_data = 1'b1;
        data_word = adc_a;
        unique case (slot)
            SLOT_B:   data_word = hold_b;
            SLOT_CRC: data_word = crc_q;
            default:  have_data = accept;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= SLOT_IDLE;
            hold_b   <= '0;
            end_pend <= 1'b0;
            crc_pend <= 1'b0;
            in_line  <= 1'b0;
        end else begin
            unique case (slot)
                SLOT_IDLE: if (pair_vld) begin
                    hold_b   <= adc_b;
                    end_pend <= line_end && (line_start || in_line);
                    crc_pend <= crc_en;
                    slot     <= SLOT_B;
                    if (line_start) in_line <= 1'b1;
                end
                SLOT_B: begin
                    slot <= (end_pend && crc_pend) ? SLOT_CRC : SLOT_IDLE;
                    if (end_pend) in_line <= 1'b0;
                end
                default: slot <= SLOT_IDLE;
            endcase
        end
    end

    lcm_crc_unit #(.W(PIX_W), .POLY(CRC_POLY)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .seed_en (seed_en),
        .fold_en (fold_en),
        .din     (fold_din),
        .crc_q   (crc_q)
    );

    lcm_out_stage #(.W(PIX_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .have_data   (have_data),
        .data_word   (data_word),
        .force_train (train_force),
        .train_word  (train_word),
        .dout        (dout),
        .dout_vld    (dout_vld)
    );

    // R2: an accepted pair shows A first
    p_a_first_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_IDLE && pair_vld && !train_force) |=> (dout_vld && dout == $past(adc_a)));

    // R2: B follows on the next edge
    p_b_second_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_IDLE && pair_vld) |=> slot == SLOT_B);

    // R4: the checksum slot lasts one cycle
    p_crc_single_r4: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_CRC) |=> slot == SLOT_IDLE);

    // R5: without the enable no checksum slot follows B
    p_no_crc_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_B && !crc_pend) |=> slot == SLOT_IDLE);

    // R8: a busy cycle leaves the held B sample alone
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (slot != SLOT_IDLE) |=> $stable(hold_b));

endmodule

// File: tb/line_crc_merger_bench.sv
module line_crc_merger_bench;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] adc_a = '0, adc_b = '0, train_word = 10'h3A5;
    logic         pair_vld = 1'b0, line_start = 1'b0, line_end = 1'b0;
    logic         crc_en = 1'b0, train_force = 1'b0;
    logic [W-1:0] dout;
    logic         dout_vld;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    line_crc_merger u_line_crc_merger (
        .clk(clk), .rst(rst), .adc_a(adc_a), .adc_b(adc_b),
        .pair_vld(pair_vld), .line_start(line_start), .line_end(line_end),
        .crc_en(crc_en), .train_force(train_force), .train_word(train_word),
        .dout(dout), .dout_vld(dout_vld)
    );

    // Checksum definition from R3: MSB first, mask 10'h24F.
    function automatic logic [W-1:0] ref_fold(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r = c;
        for (int k = 0; k < W; k++) begin
            logic top = r[W-1] ^ d[W-1-k];
            r = r << 1;
            if (top) r ^= 10'h24F;
        end
        return r;
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            1:  return "R1 reset";
            2:  return "R2 pixel word";
            4:  return "R3 R4 checksum word";
            5:  return "R5 no checksum slot";
            6:  return "R6 idle training";
            7:  return "R7 forced training";
            8:  return "R8 busy pair ignored";
            9:  return "R9 restarted line checksum";
            10: return "R10 pair outside line";
            default: return "unknown";
        endcase
    endfunction

    // Behavioural reference model.
    logic [W-1:0] q_w[$];
    int           q_t[$];
    logic [W-1:0] m_crc = '0;
    bit           m_open = 0, m_restart = 0, m_nocrc = 0;
    logic [W-1:0] exp_w = '0;
    bit           exp_v = 0;
    int           exp_t = 1;

    always @(posedge clk) begin
        if (rst) begin
            q_w.delete(); q_t.delete();
            m_open = 0; m_restart = 0; m_nocrc = 0;
            exp_w = '0; exp_v = 0; exp_t = 1;
        end else begin
            bit ign = 0;
            if (q_w.size() == 0 && pair_vld) begin
                int pt;
                pt = 2;
                m_nocrc = 0;
                if (line_start) begin
                    if (m_open) m_restart = 1;
                    m_crc = adc_a; m_open = 1;
                end else if (m_open) begin
                    m_crc = ref_fold(m_crc, adc_a);
                end else begin
                    pt = 10;
                end
                q_w.push_back(adc_a); q_t.push_back(pt);
                if (m_open) m_crc = ref_fold(m_crc, adc_b);
                q_w.push_back(adc_b); q_t.push_back(pt);
                if (line_end && m_open) begin
                    if (crc_en) begin
                        q_w.push_back(m_crc); q_t.push_back(m_restart ? 9 : 4);
                    end else m_nocrc = 1;
                    m_open = 0; m_restart = 0;
                end
            end else if (pair_vld) ign = 1;

            if (q_w.size() != 0) begin
                exp_w = q_w.pop_front(); exp_t = q_t.pop_front(); exp_v = 1;
                if (ign && exp_t == 2) exp_t = 8;
            end else begin
                exp_w = train_word; exp_v = 0;
                exp_t = m_nocrc ? 5 : 6;
                m_nocrc = 0;
            end
            if (train_force) begin
                exp_w = train_word; exp_v = 0; exp_t = 7;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished && n_checks < 100000) begin
            n_checks++;
            if (dout !== exp_w || dout_vld !== exp_v) begin
                n_fail++;
                $display("FAIL %s: got word %h vld %0d, expected word %h vld %0d",
                         tag_name(exp_t), dout, dout_vld, exp_w, exp_v);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pair_vld = 0; line_start = 0; line_end = 0; train_force = 0;
        end
    endtask

    task automatic pair(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit ls, input bit le, input bit ce, input bit frc);
        @(negedge clk);
        adc_a = a; adc_b = b; pair_vld = 1; line_start = ls; line_end = le;
        crc_en = ce; train_force = frc;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        idle(3);                                          // R6
        // R2 R3 R4: three-pair line with checksum
        pair(10'h001, 10'h002, 1, 0, 1, 0); idle(1);
        pair(10'h3FF, 10'h155, 0, 0, 1, 0); idle(1);
        pair(10'h2AA, 10'h100, 0, 1, 1, 0); idle(4);
        // R5: line without checksum
        pair(10'h0F0, 10'h00F, 1, 0, 0, 0); idle(1);
        pair(10'h111, 10'h222, 0, 1, 0, 0); idle(3);
        // single-pair line with checksum
        pair(10'h123, 10'h321, 1, 1, 1, 0); idle(4);
        // R9: restart mid-line
        pair(10'h050, 10'h060, 1, 0, 1, 0); idle(1);
        pair(10'h070, 10'h080, 1, 0, 1, 0); idle(1);
        pair(10'h090, 10'h0A0, 0, 1, 1, 0); idle(4);
        // R7: force during a line, checksum still covers it
        pair(10'h201, 10'h202, 1, 0, 1, 1); idle(1);
        pair(10'h203, 10'h204, 0, 1, 1, 0); idle(4);
        // R8: pair presented while B pending
        pair(10'h301, 10'h302, 1, 0, 1, 0);
        pair(10'h0EE, 10'h0DD, 0, 0, 1, 0);
        pair(10'h303, 10'h304, 0, 1, 1, 0); idle(4);
        // R10: pair outside a line with line_end
        pair(10'h3C3, 10'h0C0, 0, 1, 1, 0); idle(4);
        // R1: reset in mid-stream
        pair(10'h111, 10'h112, 1, 0, 1, 0);
        @(negedge clk) rst = 1; pair_vld = 0;
        idle(2); rst = 0; idle(2);
        // random mix
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            adc_a = W'($urandom); adc_b = W'($urandom);
            pair_vld = ($urandom % 3) != 0;
            line_start = ($urandom % 8) == 0;
            line_end = ($urandom % 6) == 0;
            crc_en = ($urandom % 4) != 0;
            train_force = ($urandom % 20) == 0;
            if (($urandom % 500) == 0) train_word = W'($urandom);
        end
        idle(5);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: got no end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule